// File: doc/BRIEF.md
# Accumulator ALU with Skip Logic

This block is the data path of a small 8-bit accumulator machine. On each clock it takes one operation code, the current accumulator, one operand byte, the carry and half-carry flags, the low nibble of the B address register and one register byte. It computes the new accumulator, the new flags, the decremented register value and a request to skip the next instruction. Every output leaves through one register stage, so results appear one cycle after their inputs.

Three groups of work share the path. The arithmetic group covers a plain add, an add with carry and a subtract with carry. The logic group covers bitwise AND, OR and XOR. The test group holds two accumulator compares, a compare of B's low nibble against a 4-bit immediate, and a decrement-and-test of a register. The tests change no data and only raise the skip request. The sequencer around the block decides what to do with that request, and it also handles instruction fetch, addressing and the program counter.

Top module: `acc_alu_skip`

## Requirements
- R1: Operation code 0 (ADD) returns the accumulator plus the operand modulo 256 and passes carry and half-carry through unchanged.
- R2: Operation code 1 (ADC) returns accumulator + operand + carry modulo 256. The new carry is the carry out of bit 7 and the new half-carry is the carry out of bit 3.
- R3: Operation code 2 (SUBC) returns accumulator − operand − (1 − carry) modulo 256. The carry acts as not-borrow: it is set when the full subtraction does not borrow. The half-carry is set when the low-nibble subtraction does not borrow.
- R4: Operation codes 3, 4 and 5 return accumulator AND, OR and XOR operand, with carry and half-carry unchanged.
- R5: Operation code 6 (IFEQ) raises skip exactly when the accumulator differs from the operand.
- R6: Operation code 7 (IFGT) raises skip exactly when the accumulator is not greater than the operand, compared unsigned.
- R7: Operation code 8 (IFBNE) raises skip exactly when the B nibble equals operand bits 3:0. Operand bits 7:4 have no effect.
- R8: Operation code 9 (DRSZ) returns the register minus one, wrapping 0x00 to 0xFF, and raises skip exactly when that result is zero.
- R9: The four test operations leave accumulator, carry and half-carry unchanged. Every operation other than DRSZ returns the register unchanged, and skip stays low for every operation outside the four tests.
- R10: Operation codes 10 to 15 are no-ops: every data output equals its input and skip is low.
- R11: Each output shows the result for the inputs sampled at the previous rising edge. A synchronous active-low reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_code | input | 4 | Operation code |
| acc_in | input | 8 | Current accumulator |
| opnd_in | input | 8 | Operand byte (memory or immediate) |
| carry_in | input | 1 | Current carry flag |
| hcarry_in | input | 1 | Current half-carry flag |
| bnib_in | input | 4 | Low nibble of the B register |
| reg_in | input | 8 | Register value for decrement |
| acc_out | output | 8 | New accumulator |
| carry_out | output | 1 | New carry flag |
| hcarry_out | output | 1 | New half-carry flag |
| reg_out | output | 8 | New register value |
| skip_out | output | 1 | Request to skip the next instruction |

## Verification
The block holds no state beyond its output register, so a wrong decode, a broken carry chain or a faulty compare shows at the ports one cycle after the stimulus and affects only that result. A fault in the nibble carry chain shows first at the half-carry or at bit 4 of the sum. A flipped comparison appears as a wrong skip on operands that are equal or adjacent. The bench therefore pairs random operands with the byte edges 0x00, 0x01, 0x7F, 0x80 and 0xFF, and checks every output on every cycle.

// File: rtl/acc_alu_pkg.sv
// Package: shared operation codes for the accumulator ALU.
// Assumes a 4-bit operation code; codes not listed act as no-ops.
package acc_alu_pkg;

    typedef enum logic [3:0] {
        OPC_ADD   = 4'd0,
        OPC_ADC   = 4'd1,
        OPC_SUBC  = 4'd2,
        OPC_AND   = 4'd3,
        OPC_OR    = 4'd4,
        OPC_XOR   = 4'd5,
        OPC_IFEQ  = 4'd6,
        OPC_IFGT  = 4'd7,
        OPC_IFBNE = 4'd8,
        OPC_DRSZ  = 4'd9
    } alu_opc_e;

    localparam int OPC_W = 4;

    // True for the operations that only test and may request a skip.
    function automatic logic opc_is_test(input logic [OPC_W-1:0] opc);
        return (opc == OPC_IFEQ) || (opc == OPC_IFGT) ||
               (opc == OPC_IFBNE) || (opc == OPC_DRSZ);
    endfunction

    // True for the bitwise operations.
    function automatic logic opc_is_logic(input logic [OPC_W-1:0] opc);
        return (opc == OPC_AND) || (opc == OPC_OR) || (opc == OPC_XOR);
    endfunction

    // True for the operations that use the adder.
    function automatic logic opc_is_arith(input logic [OPC_W-1:0] opc);
        return (opc == OPC_ADD) || (opc == OPC_ADC) || (opc == OPC_SUBC);
    endfunction

endpackage

// File: rtl/alu_arith_unit.sv
// Module: slice-chained adder for add, add-with-carry and subtract-with-carry.
// It subtracts by inverting the operand and using the carry as not-borrow.
// Assumes DATA_W is a whole multiple of SLICE_W. The half-carry is the
// carry out of the first slice.
module alu_arith_unit #(
    parameter int DATA_W  = 8,
    parameter int SLICE_W = 4
) (
    input  logic              sub_en,
    input  logic              cin,
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    output logic [DATA_W-1:0] sum_out,
    output logic              cout,
    output logic              hcout
);
    localparam int N_SLICE = DATA_W / SLICE_W;

    logic [DATA_W-1:0] b_eff;
    logic [N_SLICE:0]  chain;

    // Invert the operand for subtraction.
    always_comb begin
        b_eff = sub_en ? ~b_in : b_in;
    end

    assign chain[0] = cin;

    for (genvar g = 0; g < N_SLICE; g++) begin : g_slice
        logic [SLICE_W:0] part;
        // One slice of the ripple: its own sum and carry onward.
        always_comb begin
            part = {1'b0, a_in[g*SLICE_W +: SLICE_W]}
                 + {1'b0, b_eff[g*SLICE_W +: SLICE_W]}
                 + {{SLICE_W{1'b0}}, chain[g]};
        end
        assign sum_out[g*SLICE_W +: SLICE_W] = part[SLICE_W-1:0];
        assign chain[g+1] = part[SLICE_W];
    end

    assign cout  = chain[N_SLICE];
    assign hcout = chain[1];
endmodule

// File: rtl/alu_logic_unit.sv
// Module: bitwise AND, OR and XOR of accumulator and operand.
// Any operation code that is not a bitwise code returns zero;
// the top module ignores the result in that case.
module alu_logic_unit
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [OPC_W-1:0]  opc,
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    output logic [DATA_W-1:0] res_out
);
    // Choose the bitwise function.
    always_comb begin
        unique case (opc)
            OPC_AND: res_out = a_in & b_in;
            OPC_OR:  res_out = a_in | b_in;
            OPC_XOR: res_out = a_in ^ b_in;
            default: res_out = '0;
        endcase
    end
endmodule

// File: rtl/alu_skip_unit.sv
// Module: compare and decrement tests that produce the skip request.
// The nibble compare looks only at the low NIB_W bits of the operand.
// Assumes the caller masks skip for operations outside the tests.
module alu_skip_unit
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NIB_W  = 4
) (
    input  logic [OPC_W-1:0]  opc,
    input  logic [DATA_W-1:0] a_in,
    input  logic [DATA_W-1:0] b_in,
    input  logic [NIB_W-1:0]  bnib,
    input  logic [DATA_W-1:0] reg_val,
    output logic [DATA_W-1:0] reg_dec,
    output logic              skip
);
    logic eq_full, gt_full, eq_nib, dec_zero;

    // Evaluate all test conditions in parallel.
    always_comb begin
        eq_full  = (a_in == b_in);
        gt_full  = (a_in > b_in);
        eq_nib   = (bnib == b_in[NIB_W-1:0]);
        reg_dec  = reg_val - {{(DATA_W-1){1'b0}}, 1'b1};
        dec_zero = (reg_dec == '0);
    end

    // Select the skip condition for the current test.
    always_comb begin
        unique case (opc)
            OPC_IFEQ:  skip = !eq_full;
            OPC_IFGT:  skip = !gt_full;
            OPC_IFBNE: skip = eq_nib;
            OPC_DRSZ:  skip = dec_zero;
            default:   skip = 1'b0;
        endcase
    end
endmodule

// File: rtl/acc_alu_skip.sv
// Module: top of the accumulator ALU. It decodes the operation, selects
// between the arithmetic, bitwise and test units, and registers every
// output once. Assumes inputs are stable around the rising edge.
// Reset is synchronous and active low and clears all outputs.
module acc_alu_skip
    import acc_alu_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int NIB_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OPC_W-1:0]  op_code,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] opnd_in,
    input  logic              carry_in,
    input  logic              hcarry_in,
    input  logic [NIB_W-1:0]  bnib_in,
    input  logic [DATA_W-1:0] reg_in,
    output logic [DATA_W-1:0] acc_out,
    output logic              carry_out,
    output logic              hcarry_out,
    output logic [DATA_W-1:0] reg_out,
    output logic              skip_out
);
    logic [DATA_W-1:0] ar_sum, lg_res, sk_dec;
    logic              ar_cout, ar_hcout, sk_skip;
    logic              ar_sub, ar_cin;
    logic [DATA_W-1:0] nx_acc, nx_reg;
    logic              nx_c, nx_hc, nx_skip;

    // Carry-in and subtract select for the adder.
    always_comb begin
        ar_sub = (op_code == OPC_SUBC);
        ar_cin = (op_code == OPC_ADD) ? 1'b0 : carry_in;
    end

    alu_arith_unit #(.DATA_W(DATA_W), .SLICE_W(NIB_W)) arith_i (
        .sub_en (ar_sub),
        .cin    (ar_cin),
        .a_in   (acc_in),
        .b_in   (opnd_in),
        .sum_out(ar_sum),
        .cout   (ar_cout),
        .hcout  (ar_hcout)
    );

    alu_logic_unit #(.DATA_W(DATA_W)) logic_i (
        .opc    (op_code),
        .a_in   (acc_in),
        .b_in   (opnd_in),
        .res_out(lg_res)
    );

    alu_skip_unit #(.DATA_W(DATA_W), .NIB_W(NIB_W)) skip_i (
        .opc    (op_code),
        .a_in   (acc_in),
        .b_in   (opnd_in),
        .bnib   (bnib_in),
        .reg_val(reg_in),
        .reg_dec(sk_dec),
        .skip   (sk_skip)
    );

    // Select the next value of every output from the unit results.
    always_comb begin
        nx_acc  = acc_in;
        nx_c    = carry_in;
        nx_hc   = hcarry_in;
        nx_reg  = reg_in;
        nx_skip = 1'b0;
        if (opc_is_arith(op_code)) begin
            nx_acc = ar_sum;
            if (op_code != OPC_ADD) begin
                nx_c  = ar_cout;
                nx_hc = ar_hcout;
            end
        end else if (opc_is_logic(op_code)) begin
            nx_acc = lg_res;
        end else if (opc_is_test(op_code)) begin
            nx_skip = sk_skip;
            if (op_code == OPC_DRSZ) begin
                nx_reg = sk_dec;
            end
        end
    end

    // Output register stage with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_out    <= '0;
            carry_out  <= 1'b0;
            hcarry_out <= 1'b0;
            reg_out    <= '0;
            skip_out   <= 1'b0;
        end else begin
            acc_out    <= nx_acc;
            carry_out  <= nx_c;
            hcarry_out <= nx_hc;
            reg_out    <= nx_reg;
            skip_out   <= nx_skip;
        end
    end
endmodule

// File: rtl/acc_alu_skip_chk.sv
// Module: property checker for the accumulator ALU, bound to the top.
// Each property compares registered outputs with the inputs of the cycle
// before, and only applies when that cycle was out of reset.
module acc_alu_skip_chk
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NIB_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [OPC_W-1:0]  op_code,
    input logic [DATA_W-1:0] acc_in,
    input logic [DATA_W-1:0] opnd_in,
    input logic              carry_in,
    input logic              hcarry_in,
    input logic [NIB_W-1:0]  bnib_in,
    input logic [DATA_W-1:0] reg_in,
    input logic [DATA_W-1:0] acc_out,
    input logic              carry_out,
    input logic              hcarry_out,
    input logic [DATA_W-1:0] reg_out,
    input logic              skip_out
);
    AST_ADD_FLAGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_code) == OPC_ADD) |->
        (carry_out == $past(carry_in) && hcarry_out == $past(hcarry_in))); // R1

    AST_LOGIC_FLAGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && opc_is_logic($past(op_code))) |->
        (carry_out == $past(carry_in) && hcarry_out == $past(hcarry_in))); // R4

    AST_TEST_ACC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && opc_is_test($past(op_code))) |->
        (acc_out == $past(acc_in) && carry_out == $past(carry_in))); // R9

    AST_DRSZ_SKIP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_code) == OPC_DRSZ) |->
        (skip_out == (reg_out == '0))); // R8

    AST_SKIP_ONLY_TESTS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && skip_out) |-> opc_is_test($past(op_code))); // R9

    AST_REG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_code) != OPC_DRSZ) |->
        (reg_out == $past(reg_in))); // R9

    AST_IFEQ_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_code) == OPC_IFEQ) |->
        (skip_out == ($past(acc_in) != $past(opnd_in)))); // R5
endmodule

bind acc_alu_skip acc_alu_skip_chk #(.DATA_W(DATA_W), .NIB_W(NIB_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_code   (op_code),
    .acc_in    (acc_in),
    .opnd_in   (opnd_in),
    .carry_in  (carry_in),
    .hcarry_in (hcarry_in),
    .bnib_in   (bnib_in),
    .reg_in    (reg_in),
    .acc_out   (acc_out),
    .carry_out (carry_out),
    .hcarry_out(hcarry_out),
    .reg_out   (reg_out),
    .skip_out  (skip_out)
);

// File: tb/acc_alu_skip_tb_top.sv
// Bench: seeded random and directed vectors checked against a bench model.
module acc_alu_skip_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] op_code = '0;
    logic [7:0] acc_in = '0, opnd_in = '0, reg_in = '0;
    logic       carry_in = 1'b0, hcarry_in = 1'b0;
    logic [3:0] bnib_in = '0;
    logic [7:0] acc_out, reg_out;
    logic       carry_out, hcarry_out, skip_out;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    acc_alu_skip dut_i (
        .clk(clk), .rst_n(rst_n), .op_code(op_code), .acc_in(acc_in),
        .opnd_in(opnd_in), .carry_in(carry_in), .hcarry_in(hcarry_in),
        .bnib_in(bnib_in), .reg_in(reg_in), .acc_out(acc_out),
        .carry_out(carry_out), .hcarry_out(hcarry_out), .reg_out(reg_out),
        .skip_out(skip_out)
    );

    // Requirement tag for an operation code.
    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'd0: return "R1";
            4'd1: return "R2";
            4'd2: return "R3";
            4'd3, 4'd4, 4'd5: return "R4";
            4'd6: return "R5";
            4'd7: return "R6";
            4'd8: return "R7";
            4'd9: return "R8";
            default: return "R10";
        endcase
    endfunction

    // Bench model: {acc, c, hc, reg, skip} packed into 19 bits.
    function automatic logic [18:0] model(input logic [3:0] op, input logic [7:0] a,
            input logic [7:0] b, input logic c, input logic hc,
            input logic [3:0] bn, input logic [7:0] r);
        logic [7:0] na = a, nr = r;
        logic nc = c, nh = hc, sk = 1'b0;
        int t, tl;
        case (op)
            4'd0: na = 8'((int'(a) + int'(b)) % 256);
            4'd1: begin
                t = int'(a) + int'(b) + int'(c);
                tl = int'(a[3:0]) + int'(b[3:0]) + int'(c);
                na = 8'(t % 256); nc = (t > 255); nh = (tl > 15);
            end
            4'd2: begin
                t = int'(a) - int'(b) - (1 - int'(c));
                tl = int'(a[3:0]) - int'(b[3:0]) - (1 - int'(c));
                na = 8'((t + 512) % 256); nc = (t >= 0); nh = (tl >= 0);
            end
            4'd3: na = a & b;
            4'd4: na = a | b;
            4'd5: na = a ^ b;
            4'd6: sk = (a != b);
            4'd7: sk = !(a > b);
            4'd8: sk = (bn == b[3:0]);
            4'd9: begin nr = 8'((int'(r) + 255) % 256); sk = (nr == 8'h00); end
            default: ;
        endcase
        return {na, nc, nh, nr, sk};
    endfunction

    // Apply one vector at a falling edge and check it at the next one (R11).
    task automatic run_vec(input logic [3:0] op, input logic [7:0] a,
            input logic [7:0] b, input logic c, input logic hc,
            input logic [3:0] bn, input logic [7:0] r);
        logic [18:0] exp, act;
        @(negedge clk);
        op_code = op; acc_in = a; opnd_in = b; carry_in = c;
        hcarry_in = hc; bnib_in = bn; reg_in = r;
        exp = model(op, a, b, c, hc, bn, r);
        @(negedge clk);
        act = {acc_out, carry_out, hcarry_out, reg_out, skip_out};
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s R9 R11 op=%0d a=%h b=%h c=%b r=%h: actual=%h expected=%h",
                     req_of(op), op, a, b, c, r, act, exp);
        end
    endtask

    initial begin
        void'($urandom(32'h0C0FFEE5));
        // R11: reset clears every output.
        repeat (3) @(negedge clk);
        n_chk++;
        if ({acc_out, carry_out, hcarry_out, reg_out, skip_out} !== 19'd0) begin
            n_fail++;
            $display("FAIL R11 reset: actual=%h expected=0",
                     {acc_out, carry_out, hcarry_out, reg_out, skip_out});
        end
        rst_n = 1'b1;
        // R1 wrap at 0xFF, flags pass through.
        run_vec(4'd0, 8'hFF, 8'h01, 1'b1, 1'b0, 4'h0, 8'h33);
        // R2 carries out of bit 3 and bit 7.
        run_vec(4'd1, 8'hFF, 8'h00, 1'b1, 1'b0, 4'h0, 8'h00);
        run_vec(4'd1, 8'h0F, 8'h00, 1'b1, 1'b0, 4'h0, 8'h00);
        run_vec(4'd1, 8'h7F, 8'h80, 1'b0, 1'b1, 4'h0, 8'h00);
        // R3 borrow at 0x00, no borrow on equal with carry set.
        run_vec(4'd2, 8'h00, 8'h00, 1'b0, 1'b0, 4'h0, 8'h00);
        run_vec(4'd2, 8'h55, 8'h55, 1'b1, 1'b0, 4'h0, 8'h00);
        run_vec(4'd2, 8'h10, 8'h01, 1'b1, 1'b1, 4'h0, 8'h00);
        // R4 bitwise.
        run_vec(4'd3, 8'hF0, 8'h3C, 1'b1, 1'b1, 4'h0, 8'h00);
        run_vec(4'd4, 8'hF0, 8'h3C, 1'b0, 1'b1, 4'h0, 8'h00);
        run_vec(4'd5, 8'hF0, 8'h3C, 1'b1, 1'b0, 4'h0, 8'h00);
        // R5, R6 equal and adjacent values.
        run_vec(4'd6, 8'h80, 8'h80, 1'b0, 1'b0, 4'h0, 8'h00);
        run_vec(4'd6, 8'h80, 8'h7F, 1'b0, 1'b0, 4'h0, 8'h00);
        run_vec(4'd7, 8'h80, 8'h7F, 1'b0, 1'b0, 4'h0, 8'h00);
        run_vec(4'd7, 8'h7F, 8'h7F, 1'b0, 1'b0, 4'h0, 8'h00);
        run_vec(4'd7, 8'h00, 8'hFF, 1'b0, 1'b0, 4'h0, 8'h00);
        // R7 upper operand bits ignored.
        run_vec(4'd8, 8'h00, 8'hA5, 1'b0, 1'b0, 4'h5, 8'h00);
        run_vec(4'd8, 8'h00, 8'h05, 1'b0, 1'b0, 4'h5, 8'h00);
        run_vec(4'd8, 8'h00, 8'h56, 1'b0, 1'b0, 4'h5, 8'h00);
        // R8 decrement from 0x01 and from 0x00.
        run_vec(4'd9, 8'h12, 8'h00, 1'b1, 1'b1, 4'h0, 8'h01);
        run_vec(4'd9, 8'h12, 8'h00, 1'b1, 1'b1, 4'h0, 8'h00);
        run_vec(4'd9, 8'h12, 8'h00, 1'b0, 1'b0, 4'h0, 8'h02);
        // R10 no-op codes.
        for (int k = 10; k < 16; k++)
            run_vec(4'(k), 8'hA7, 8'h5A, 1'b1, 1'b0, 4'h7, 8'hC3);
        // Random mix across all requirements.
        for (int i = 0; i < 3000; i++)
            run_vec(4'($urandom_range(0, 15)), 8'($urandom), 8'($urandom),
                    1'($urandom), 1'($urandom), 4'($urandom), 8'($urandom));
        // R11 synchronous reset mid-run clears outputs.
        @(negedge clk);
        op_code = 4'd9; reg_in = 8'h01; rst_n = 1'b0;
        @(negedge clk);
        n_chk++;
        if ({acc_out, carry_out, hcarry_out, reg_out, skip_out} !== 19'd0) begin
            n_fail++;
            $display("FAIL R11 mid reset: actual=%h expected=0",
                     {acc_out, carry_out, hcarry_out, reg_out, skip_out});
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule